// File: doc/BRIEF.md
# Audio Serial Output Port

This block turns a stream of 16-bit stereo sample pairs into a three-wire serial audio output: a frame clock, a bit clock and a serial data line. It is always the clock master. All three outputs come from a single fast system clock, and the bit clock is produced by a fixed divider. A new left/right pair is taken through a ready/valid handshake once per frame. If no pair is waiting when a frame starts, the previous pair is sent again and an underrun pulse is raised.

A 2-bit format input selects one of four framings: two DSP-style framings that mark each frame with a rising frame-clock edge, an MSB-justified framing, and an I2S-compatible framing. In the DSP framings, one bit selects which bit-clock edge launches the data. A second bit delays every data bit by half a bit period. Together they give four DSP timing variants. The format and both DSP bits are sampled once per frame, at the frame start. A change made in the middle of a frame therefore has no effect until the next frame.

Top module: `aud_ser_tx`

## Requirements
- R1: Format (0 = DSP A, 1 = DSP B, 2 = MSB justified, 3 = I2S), edge select, shift and the sample pair are all captured at the frame start. Changes made later in a frame leave that frame's outputs unchanged.
- R2: Each frame sends left then right. Each channel has SLOTS bit slots. Each word is sent as 16-bit two's complement, MSB first, in the first 16 slots, and any slots after those carry 0.
- R3: The bit clock has 50% duty. It changes level every HALF_DIV system clocks. A frame lasts 2*SLOTS bit periods.
- R4: MSB justified: the frame clock is high for the left channel and low for the right. The left MSB starts at the frame-clock rise. Data changes only on falling bit-clock edges.
- R5: I2S: the frame clock is low for the left channel. It falls one bit period before the left MSB, and it rises one bit period before the right MSB. Data changes only on falling bit-clock edges.
- R6: DSP A (format 0): the frame clock is high for one bit period per frame. DSP B (format 1): it is high for SLOTS bit periods starting at the same rise.
- R7: DSP, shift 0: the frame clock rises on the edge opposite the launch edge. The MSB follows half a bit period later, on the launch edge: the rising edge when edge select is 0 and the falling edge when it is 1.
- R8: DSP, shift 1: every bit launches half a bit period later, on the edge of opposite polarity. The frame clock then rises one full bit period before the MSB.
- R9: in_ready is high for exactly one system clock per frame. When in_valid is high in that cycle, the pair on in_left/in_right is the pair sent in the frame that starts next.
- R10: When in_ready is high and in_valid is low, underrun is high for that cycle and the previous pair is sent again. underrun is low at every other time.
- R11: While reset is held and until the first frame starts: frame clock 0, bit clock 1, data 0, in_ready 0 and underrun 0. The format after reset is MSB justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Framing format select |
| cfg_edge | input | 1 | DSP launch edge: 0 rising, 1 falling |
| cfg_shift | input | 1 | DSP half-bit data delay |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Pair taken this cycle (frame start) |
| in_left | input | 16 | Left sample |
| in_right | input | 16 | Right sample |
| fclk | output | 1 | Frame clock |
| bclk | output | 1 | Bit clock |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | No pair was valid at the frame start |

## Verification
The bench builds the block with HALF_DIV = 3 and SLOTS = 18. The odd divider shows that a half-period offset lands on a system clock edge even when a bit period is not a power of two. The two spare slots per channel bring the zero-padding of R2 within reach, as well as the I2S case where the right LSB falls before the frame clock changes. The 72-half frame is short enough that all eight format and DSP variants can be captured over two whole frames each, together with the mid-frame change and the underrun repeat.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int HALF_DIV = 4,
  parameter int SLOTS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_fmt,
  input  logic        cfg_edge,
  input  logic        cfg_shift,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_left,
  input  logic [15:0] in_right,
  output logic        fclk,
  output logic        bclk,
  output logic        sdata,
  output logic        underrun
);
  localparam int W  = 16;
  localparam int N  = 4 * SLOTS;
  localparam int H  = 2 * SLOTS;
  localparam int PW = $clog2(N);
  localparam int DW = $clog2(HALF_DIV);

  logic [DW-1:0] div_q;
  logic [PW-1:0] pos_q;
  logic [1:0]    fmt_q;
  logic          edge_q, shift_q;
  logic [W-1:0]  left_q, right_q;

  logic tick, last;
  assign tick     = div_q == DW'(HALF_DIV - 1);
  assign last     = pos_q == PW'(N - 1);
  assign in_ready = tick & last;
  assign underrun = in_ready & ~in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      pos_q   <= PW'(N - 1);
      fmt_q   <= 2'd2;
      edge_q  <= 1'b0;
      shift_q <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) pos_q <= last ? '0 : pos_q + 1'b1;
      if (in_ready) begin
        fmt_q   <= cfg_fmt;
        edge_q  <= cfg_edge;
        shift_q <= cfg_shift;
        if (in_valid) begin
          left_q  <= in_left;
          right_q <= in_right;
        end
      end
    end
  end

  logic [1:0] off;
  always_comb begin
    case (fmt_q)
      2'd2:    off = 2'd0;
      2'd3:    off = 2'd2;
      default: off = 2'd1 + {1'b0, shift_q};
    endcase
  end

  logic [PW:0] rsum, ref_pos;
  assign rsum    = {1'b0, pos_q} + (PW+1)'(off);
  assign ref_pos = (rsum >= (PW+1)'(N)) ? rsum - (PW+1)'(N) : rsum;

  always_comb begin
    case (fmt_q)
      2'd0:    fclk = ref_pos < (PW+1)'(2);
      2'd3:    fclk = ref_pos >= (PW+1)'(H);
      default: fclk = ref_pos < (PW+1)'(H);
    endcase
  end

  assign bclk = ref_pos[0] ^ (~fmt_q[1] & edge_q);

  logic [PW-2:0] bit_idx, slot;
  logic          chan;
  logic [W-1:0]  mask;
  assign bit_idx = pos_q[PW-1:1];
  assign chan    = bit_idx >= (PW-1)'(SLOTS);
  assign slot    = chan ? bit_idx - (PW-1)'(SLOTS) : bit_idx;
  assign mask    = {1'b1, {(W-1){1'b0}}} >> slot;
  assign sdata   = |((chan ? right_q : left_q) & mask);
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       fclk,
  input logic       bclk,
  input logic       sdata,
  input logic [1:0] fmt_q,
  input logic       edge_q,
  input logic       shift_q
);
  p_ready_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  p_bclk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bclk) && $stable(fmt_q) && $stable(edge_q) && $stable(shift_q)) |=> $stable(bclk));

  p_fclk_on_bclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fclk) && $stable(fmt_q) && $stable(edge_q) && $stable(shift_q)) |-> !$stable(bclk));

  p_std_fall_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q[1] && $stable(fmt_q) && !$stable(sdata)) |-> $fell(bclk));

  p_dsp_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_q[1] && $stable(fmt_q) && $stable(edge_q) && $stable(shift_q) && !$stable(sdata))
      |-> (bclk == (shift_q ^ ~edge_q)));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .fclk(fclk), .bclk(bclk),
  .sdata(sdata), .fmt_q(fmt_q), .edge_q(edge_q), .shift_q(shift_q)
);

// File: tb/tb_aud_ser_tx.sv
module tb_aud_ser_tx;
  localparam int HD = 3;
  localparam int SL = 18;
  localparam int N  = 4 * SL;
  localparam int H  = 2 * SL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_fmt = 2'd2;
  logic cfg_edge = 1'b0, cfg_shift = 1'b0, in_valid = 1'b0;
  logic [15:0] in_left = '0, in_right = '0;
  logic in_ready, fclk, bclk, sdata, underrun;

  int n_chk = 0, n_err = 0;
  logic cf [0:2*N-1];
  logic cb [0:2*N-1];
  logic cd [0:2*N-1];

  always #5 clk = ~clk;

  aud_ser_tx #(.HALF_DIV(HD), .SLOTS(SL)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_edge(cfg_edge),
    .cfg_shift(cfg_shift), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .fclk(fclk), .bclk(bclk),
    .sdata(sdata), .underrun(underrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic capture(input int halves);
    for (int c = 0; c < halves; c++) begin
      if (c == 0) @(negedge clk); else repeat (HD) @(negedge clk);
      cf[c] = fclk; cb[c] = bclk; cd[c] = sdata;
    end
  endtask

  function automatic int exp_data(input int j, input logic [15:0] l, input logic [15:0] r);
    int bi, slot;
    logic [15:0] w;
    bi = j / 2;
    w = (bi >= SL) ? r : l;
    slot = (bi >= SL) ? bi - SL : bi;
    return (slot < 16) ? int'(w[15 - slot]) : 0;
  endfunction

  function automatic int exp_fclk(input int fmt, input int sh, input int j);
    int jm, a;
    jm = ((j % N) + N) % N;
    a = (jm + 1 + sh) % N;
    case (fmt)
      0: return (a < 2) ? 1 : 0;
      1: return (a < H) ? 1 : 0;
      2: return (jm < H) ? 1 : 0;
      default: return (jm >= H - 2 && jm < N - 2) ? 1 : 0;
    endcase
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11", "fclk in reset", fclk, 0);
    chk("R11", "bclk in reset", bclk, 1);
    chk("R11", "sdata in reset", sdata, 0);
    chk("R11", "in_ready in reset", in_ready, 0);
    chk("R11", "underrun in reset", underrun, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "fclk after release", fclk, 0);
    chk("R11", "bclk after release", bclk, 1);
    chk("R11", "in_ready after release", in_ready, 0);
  endtask

  task automatic run_fmt(input int fmt, input int ed, input int sh,
                         input logic [15:0] l, input logic [15:0] r);
    string ftag;
    int exp_new;
    ftag = (fmt == 2) ? "R4" : (fmt == 3) ? "R5" : "R6";
    cfg_fmt = 2'(fmt); cfg_edge = ed[0]; cfg_shift = sh[0];
    in_left = l; in_right = r; in_valid = 1'b1;
    wait_ready();
    capture(2 * N);
    for (int j = -N; j < N; j++)
      chk(ftag, $sformatf("fmt%0d e%0d s%0d fclk half %0d", fmt, ed, sh, j),
          cf[j + N], exp_fclk(fmt, sh, j));
    for (int c = 1; c < 2 * N; c++)
      chk("R3", $sformatf("fmt%0d bclk toggles at half %0d", fmt, c), cb[c], ~cb[c-1] & 1'b1);
    for (int j = 0; j < N; j++)
      chk("R2", $sformatf("fmt%0d e%0d s%0d data half %0d (R9 pair)", fmt, ed, sh, j),
          cd[j + N], exp_data(j, l, r));
    if (fmt >= 2) exp_new = 0;
    else exp_new = sh ? ed : 1 - ed;
    chk((fmt >= 2) ? ftag : (sh ? "R8" : "R7"),
        $sformatf("fmt%0d e%0d s%0d bclk level at MSB launch", fmt, ed, sh), cb[N], exp_new);
  endtask

  task automatic t_timing();
    int rdy, bch;
    logic prev;
    cfg_fmt = 2'd3; cfg_edge = 1'b0; cfg_shift = 1'b0; in_valid = 1'b1;
    wait_ready();
    wait_ready();
    rdy = 0; bch = 0; prev = bclk;
    repeat (5 * N * HD) begin
      @(negedge clk);
      if (in_ready) rdy++;
      if (bclk != prev) bch++;
      prev = bclk;
    end
    chk("R9", "ready pulses in five frames", rdy, 5);
    chk("R3", "bclk changes in five frames", bch, 5 * N);
  endtask

  task automatic t_underrun();
    cfg_fmt = 2'd2; cfg_edge = 1'b0; cfg_shift = 1'b0;
    in_left = 16'h7F01; in_right = 16'h8000; in_valid = 1'b1;
    wait_ready();
    chk("R10", "underrun low when valid", underrun, 0);
    @(posedge clk); #1;
    in_valid = 1'b0; in_left = 16'h1234; in_right = 16'h5678;
    chk("R10", "underrun low between frames", underrun, 0);
    wait_ready();
    chk("R10", "underrun high when not valid", underrun, 1);
    capture(N);
    for (int j = 0; j < N; j++)
      chk("R10", $sformatf("repeated pair data half %0d", j), cd[j], exp_data(j, 16'h7F01, 16'h8000));
    in_valid = 1'b1;
  endtask

  task automatic t_midframe();
    cfg_fmt = 2'd2; cfg_edge = 1'b0; cfg_shift = 1'b0;
    in_left = 16'hC0DE; in_right = 16'h0F0F; in_valid = 1'b1;
    wait_ready();
    for (int c = 0; c < N; c++) begin
      if (c == 0) @(negedge clk); else repeat (HD) @(negedge clk);
      cf[c] = fclk; cd[c] = sdata;
      if (c == H + 2) begin
        cfg_fmt = 2'd3; cfg_edge = 1'b1; cfg_shift = 1'b1; in_right = 16'hF0F0;
      end
    end
    for (int j = 0; j < N; j++) begin
      chk("R1", $sformatf("fclk keeps format at half %0d", j), cf[j], exp_fclk(2, 0, j));
      chk("R1", $sformatf("data keeps pair at half %0d", j), cd[j], exp_data(j, 16'hC0DE, 16'h0F0F));
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    t_reset();
    run_fmt(2, 0, 0, 16'hA5C3, 16'h3C5A);
    run_fmt(3, 0, 0, 16'h8001, 16'hFFFF);
    run_fmt(0, 0, 0, 16'h1357, 16'hECA8);
    run_fmt(0, 1, 0, 16'hFFFE, 16'h0001);
    run_fmt(0, 0, 1, 16'h6DB6, 16'h9249);
    run_fmt(0, 1, 1, 16'h0F00, 16'hF00F);
    run_fmt(1, 0, 0, 16'h4321, 16'hBEEF);
    run_fmt(1, 1, 1, 16'h7FFF, 16'h8000);
    t_timing();
    t_underrun();
    t_midframe();
    report();
    $finish;
  end
endmodule